// File: doc/BRIEF.md
# Two-Step Half-Flash Result Encoder

This block turns the comparator outputs of a two-step (half-flash) converter into an 8-bit code. A coarse bank of 15 comparators, each giving one thermometer bit, is encoded into the upper nibble when the sequencer pulses the coarse strobe. That nibble is held and driven out as the code for the residue DAC. Once the residue has settled, a fine bank of 15 comparators is encoded into the lower nibble when the sequencer pulses the fine strobe. Only then is the full result loaded and announced with a one-cycle valid pulse.

The encoder counts the ones in each thermometer word. A word that is not a clean run of ones from bit 0 upward (a one sitting above a zero) still encodes as its count of ones, and it raises an error flag for that conversion. A static view select can present the offset-binary result as a signed two's-complement value, so that mid-scale reads as zero.

Top module: `halfflash_encoder`

## Requirements
- R1: After reset, `result`, `dac_code`, `result_valid` and `bubble_err` are all zero.
- R2: On a clock edge with `coarse_latch` high, `dac_code` takes the number of ones in `coarse_therm`. Without that strobe, `dac_code` keeps its value whatever `coarse_therm` does.
- R3: On a clock edge with `fine_latch` high, the stored result becomes {`dac_code` as held before that edge, number of ones in `fine_therm`}. Without that strobe the stored result does not change.
- R4: `result_valid` is high for exactly the one cycle that follows each clock edge at which `fine_latch` was high, and is low at all other times.
- R5: An all-zero thermometer on both banks yields 8'h00. An all-ones thermometer (15 ones) on both banks yields 8'hFF.
- R6: A thermometer word with a one above a zero (bit i+1 set while bit i is clear) is encoded as its count of ones.
- R7: `bubble_err` is loaded at a coarse strobe with the coarse word's bubble status. A fine strobe ORs in the fine word's bubble status. The flag therefore reports a bubble in either stage of the latest conversion and clears at the next conversion whose coarse word is clean.
- R8: With `bipolar` = 0, `result` shows the stored code unchanged. With `bipolar` = 1, `result` shows the stored code with its bit 7 inverted (two's complement), so the mid-scale code 8'h80 reads as 8'h00. The select acts combinationally.
- R9: Several fine strobes after one coarse strobe all reuse the same held upper nibble, even if `coarse_therm` changes in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| coarse_therm | input | 15 | Coarse comparator bank, bit 0 lowest threshold |
| coarse_latch | input | 1 | Strobe: encode and hold the upper nibble |
| fine_therm | input | 15 | Fine comparator bank against the residue |
| fine_latch | input | 1 | Strobe: encode the lower nibble and load the result |
| bipolar | input | 1 | 1 selects the two's-complement view of the result |
| dac_code | output | 4 | Held upper nibble that drives the residue DAC |
| result | output | 8 | Stored 8-bit result in the selected view |
| result_valid | output | 1 | One-cycle pulse after each fine strobe |
| bubble_err | output | 1 | A bubble was seen in the latest conversion |

## Verification
Faults in the held upper nibble show up at two points. They appear on `dac_code` one cycle after the coarse strobe. They also appear in the upper half of the next result, even when the coarse inputs have changed since that strobe. A wrong count or a missed bubble in either encoder shows up at the following valid pulse, in the result nibble or in `bubble_err`. A valid that is missing, extra or stretched shows up one cycle after the fine strobe, because every conversion expects exactly one result in order.

// File: rtl/hf_pkg.sv
package hf_pkg;
  typedef enum logic {
    VIEW_STRAIGHT = 1'b0,
    VIEW_SIGNED   = 1'b1
  } hf_view_e;
endpackage

// File: rtl/hf_therm_enc.sv
module hf_therm_enc #(
  parameter int NIB_W = 4
) (
  input  logic [(2**NIB_W)-2:0] therm,
  output logic [NIB_W-1:0]      count,
  output logic                  bubble
);
  localparam int TW = (2**NIB_W) - 1;

  logic [TW-2:0] gap;

  // a one directly above a zero marks a bubble
  genvar g;
  generate
    for (g = 0; g < TW - 1; g++) begin : g_gap
      assign gap[g] = therm[g+1] & ~therm[g];
    end
  endgenerate

  assign bubble = |gap;

  always_comb begin
    count = '0;
    for (int i = 0; i < TW; i++) begin
      count = count + NIB_W'(therm[i]);
    end
  end

  // R6: a clean word is exactly a run of ones of length count
  always_comb begin
    if (bubble == 1'b0) begin
      clean_word_chk: assert (therm == TW'((1 << count) - 1));
    end
  end
endmodule

// File: rtl/hf_nib_latch.sv
module hf_nib_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (load) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  // R2 R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/halfflash_encoder.sv
module halfflash_encoder #(
  parameter int NIB_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [(2**NIB_W)-2:0]     coarse_therm,
  input  logic                      coarse_latch,
  input  logic [(2**NIB_W)-2:0]     fine_therm,
  input  logic                      fine_latch,
  input  logic                      bipolar,
  output logic [NIB_W-1:0]          dac_code,
  output logic [2*NIB_W-1:0]        result,
  output logic                      result_valid,
  output logic                      bubble_err
);
  import hf_pkg::*;

  localparam int RW = 2 * NIB_W;

  logic [NIB_W-1:0] coarse_cnt, fine_cnt;
  logic             coarse_bub, fine_bub;
  logic [RW-1:0]    raw_q;
  logic             valid_next, err_next;
  hf_view_e         view;

  hf_therm_enc #(.NIB_W(NIB_W)) u_enc_coarse (
    .therm(coarse_therm), .count(coarse_cnt), .bubble(coarse_bub));

  hf_therm_enc #(.NIB_W(NIB_W)) u_enc_fine (
    .therm(fine_therm), .count(fine_cnt), .bubble(fine_bub));

  hf_nib_latch #(.W(NIB_W)) u_upper (
    .clk(clk), .rst_n(rst_n), .load(coarse_latch),
    .d(coarse_cnt), .q(dac_code));

  hf_nib_latch #(.W(RW)) u_result (
    .clk(clk), .rst_n(rst_n), .load(fine_latch),
    .d({dac_code, fine_cnt}), .q(raw_q));

  always_comb begin
    valid_next = fine_latch;
    err_next   = coarse_latch ? coarse_bub : bubble_err;
    if (fine_latch) err_next = err_next | fine_bub;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      bubble_err   <= 1'b0;
    end else begin
      result_valid <= valid_next;
      bubble_err   <= err_next;
    end
  end

  assign view   = hf_view_e'(bipolar);
  assign result = (view == VIEW_SIGNED) ? (raw_q ^ {1'b1, {(RW-1){1'b0}}}) : raw_q;

  // R4
  valid_after_fine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fine_latch |=> result_valid);

  // R4
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_latch |=> !result_valid);

  // R7
  clean_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_latch && !coarse_bub && !fine_latch) |=> !bubble_err);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!coarse_latch && !fine_latch) |=> $stable(bubble_err));
endmodule

// File: tb/test_halfflash_encoder.sv
module test_halfflash_encoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [14:0] coarse_therm, fine_therm;
  logic        coarse_latch, fine_latch, bipolar;
  logic [3:0]  dac_code;
  logic [7:0]  result;
  logic        result_valid, bubble_err;

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q[$];   // {err, raw}

  always #4 clk = ~clk;

  halfflash_encoder i_halfflash_encoder (
    .clk(clk), .rst_n(rst_n),
    .coarse_therm(coarse_therm), .coarse_latch(coarse_latch),
    .fine_therm(fine_therm), .fine_latch(fine_latch),
    .bipolar(bipolar), .dac_code(dac_code), .result(result),
    .result_valid(result_valid), .bubble_err(bubble_err));

  function automatic logic [14:0] therm(input int n);
    return 15'((1 << n) - 1);
  endfunction

  function automatic logic has_bub(input logic [14:0] t);
    return t != therm($countones(t));
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  logic [3:0] held_up;
  logic       held_err;

  task automatic coarse(input logic [14:0] c);
    @(negedge clk);
    coarse_therm = c; coarse_latch = 1'b1;
    @(negedge clk);
    coarse_latch = 1'b0;
    held_up  = 4'($countones(c));
    held_err = has_bub(c);
    chk("R2 dac_code", {5'd0, dac_code}, {5'd0, held_up});
    coarse_therm = ~c;
    @(negedge clk);
    chk("R2 hold", {5'd0, dac_code}, {5'd0, held_up});
  endtask

  task automatic fine(input logic [14:0] f);
    @(negedge clk);
    fine_therm = f; fine_latch = 1'b1;
    held_err = held_err | has_bub(f);
    exp_q.push_back({held_err, held_up, 4'($countones(f))});
    @(negedge clk);
    fine_latch = 1'b0;
    @(negedge clk);
    chk("R4 pulse width", {8'd0, result_valid}, 9'd0);
  endtask

  task automatic conv(input logic [14:0] c, input logic [14:0] f);
    coarse(c);
    fine(f);
  endtask

  // monitor: samples 2 ns after each rising edge
  always begin
    @(posedge clk); #2;
    if (rst_n && result_valid) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected valid", 9'd1, 9'd0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if (bipolar) e[7] = ~e[7];
        chk("R3 R5 R6 R7 R8 result", {bubble_err, result}, e);
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; coarse_therm = '0; fine_therm = '0;
    coarse_latch = 1'b0; fine_latch = 1'b0; bipolar = 1'b0;
    held_up = '0; held_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset", {bubble_err, result}, 9'd0);
    chk("R1 reset", {result_valid, 4'd0, dac_code}, 9'd0);
    rst_n = 1'b1;
    @(negedge clk);

    conv(therm(0), therm(0));           // R5 zero
    conv(therm(15), therm(15));         // R5 full
    for (int k = 1; k < 15; k += 3) conv(therm(k), therm(14 - k));

    conv(therm(8), therm(0));           // R8 mid-scale, straight
    bipolar = 1'b1;
    conv(therm(8), therm(0));           // R8 mid-scale reads zero
    conv(therm(3), therm(9));           // R8
    @(negedge clk);
    chk("R8 combinational view", {1'b0, result}, 9'h039 ^ 9'h080);
    bipolar = 1'b0;
    #1;
    chk("R8 combinational view", {1'b0, result}, 9'h039);

    conv(15'b000_0000_0101_0111, therm(2));   // R6 coarse bubble, R7 set
    conv(therm(4), therm(4));                 // R7 cleared by clean coarse
    conv(therm(6), 15'b100_0000_0000_0011);   // R6 fine bubble, R7 set by fine

    coarse(therm(11));                        // R9 reuse held nibble
    fine(therm(1));
    fine(therm(13));
    fine(15'h7FFF);

    repeat (4) @(negedge clk);
    chk("R4 every conversion reported", {1'b0, 8'(exp_q.size())}, 9'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule